// File: doc/BRIEF.md
# Audio bit clock and frame sync generator

This block produces the serial bit clock and the frame-sync strobe of a PCM audio port. It runs in the system clock domain. Either of two source clocks reaches it as a one-cycle tick: one from the audio clock mux, one from the peripheral bus clock. A 20-bit clock-control word, loaded through a write strobe, selects the source and sets two 9-bit counts. One count sets the bit-clock half period in source ticks. The other sets how many bit clocks make up one frame.

The bit clock is a level output. It also comes with one-cycle rise and fall pulses that downstream serialisers can use as enables. The frame-sync level is high for the first bit clock of every frame. The generator runs only while its serial-clock enable is set and the port is either active or in continuous-idle mode. Otherwise the clock stops. Any register write restarts both counters. This also covers switching the source, so a change of source never leaves a partly counted phase.

The controller is a three-state machine:
- `ST_OFF`: clock held low, counters cleared.
- `ST_LOW`: low half of a bit clock.
- `ST_HIGH`: high half of a bit clock.

Transitions:
- OFF→LOW: on the first cycle the run condition holds.
- LOW→HIGH: the half-period count has expired (this is the rise).
- HIGH→LOW: the half-period count has expired (this is the fall, which also advances the frame count).
- Any state→OFF: on a register write or when the run condition drops.

Top module: `pcm_clkgen`

## Requirements
- R1: The control word is decoded by bit position. Bits 8:0 are the frame count S. Bits 17:9 are the bit-clock divider N. Bit 18 selects the source: 1 selects `tick_bus`, 0 selects `tick_audio`. Bit 19 is the serial-clock enable.
- R2: After reset, `bclk`, `bclk_rise`, `bclk_fall` and `fsync` are all 0, and the serial-clock enable is clear.
- R3: While running, each high half and each low half of `bclk` lasts exactly N+1 ticks of the selected source. The bit-clock period is therefore 2×(N+1) ticks.
- R4: Ticks on the unselected source have no effect on `bclk`.
- R5: `fsync` is high for exactly one bit-clock period at the start of each frame, from the frame's low half up to its first fall. It repeats every S+1 bit clocks.
- R6: `bclk_rise` is a one-cycle pulse in the first cycle that `bclk` reads 1 after being 0. `bclk_fall` is a one-cycle pulse in the first cycle that `bclk` reads 0 after a high half.
- R7: A write to the control word restarts the generator. In the cycle after the write edge, `bclk`, `fsync` and both pulses are 0, and both counts restart from zero.
- R8: While the serial-clock enable is 0, `bclk` and `fsync` stay 0 whatever the tick inputs do.
- R9: With `keep_idle_clk`=1, the clock keeps running while `port_active`=0. With `keep_idle_clk`=0, `bclk` and `fsync` are 0 from the cycle after `port_active` falls.
- R10: Suppose the selected source ticks every cycle and a write leaves the generator running. Then the first `bclk_rise` appears N+2 clock edges after the write edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Control word write strobe |
| cfg_wdata | input | 20 | Control word value |
| tick_audio | input | 1 | One-cycle tick from the audio mux clock |
| tick_bus | input | 1 | One-cycle tick from the peripheral bus clock |
| port_active | input | 1 | A transfer is in progress on the port |
| keep_idle_clk | input | 1 | 1: clock runs while idle; 0: clock gated when idle |
| bclk | output | 1 | Serial bit clock level |
| bclk_rise | output | 1 | Pulse in the first cycle of each high half |
| bclk_fall | output | 1 | Pulse in the first cycle of each low half |
| fsync | output | 1 | Frame-sync level, high for the first bit clock of a frame |

## Verification
Two events can land on the same clock edge:
- a control-word write and the expiry of a half period, which would otherwise produce a rise, a fall or a frame wrap;
- the run condition dropping while a selected tick arrives.

The random phase issues writes, enable changes and activity changes at arbitrary moments while both tick inputs toggle randomly, so these collisions occur repeatedly. A cycle-level reference model in the bench gives the write or the stop priority over the toggle. It compares all four outputs on every cycle, so a collision that leaks a pulse or skips the restart shows up as a mismatch.

// File: rtl/pcm_clkgen_pkg.sv
package pcm_clkgen_pkg;

    localparam int DIV_W  = 9;
    localparam int CFG_W  = 2 * DIV_W + 2;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2
    } gen_state_e;

    // Packed MSB-first so the struct lines up with the control word layout
    typedef struct packed {
        logic             ser_en;
        logic             src_sel;
        logic [DIV_W-1:0] bclk_div;
        logic [DIV_W-1:0] sync_div;
    } clk_cfg_t;

endpackage

// File: rtl/pcm_cfg_reg.sv
module pcm_cfg_reg
    import pcm_clkgen_pkg::*;
#(
    parameter int SYNC_RST = 127,
    parameter int DIV_RST  = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [CFG_W-1:0] wdata,
    output clk_cfg_t         cfg
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg.ser_en   <= 1'b0;
            cfg.src_sel  <= 1'b0;
            cfg.bclk_div <= DIV_W'(DIV_RST);
            cfg.sync_div <= DIV_W'(SYNC_RST);
        end else if (wr) begin
            cfg <= clk_cfg_t'(wdata);
        end
    end

    // A write must land field by field at the documented bit positions
    assert_wr_capture_R1: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (cfg.sync_div == $past(wdata[DIV_W-1:0]))
            && (cfg.bclk_div == $past(wdata[2*DIV_W-1:DIV_W]))
            && (cfg.src_sel  == $past(wdata[2*DIV_W]))
            && (cfg.ser_en   == $past(wdata[2*DIV_W+1])));

endmodule

// File: rtl/pcm_tick_div.sv
module pcm_tick_div #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         tick,
    input  logic [W-1:0] limit,
    output logic         term
);

    logic [W-1:0] cnt_q;

    assign term = tick && (cnt_q == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (tick) begin
            if (cnt_q == limit) cnt_q <= '0;
            else                cnt_q <= cnt_q + 1'b1;
        end
    end

    assert_half_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (cnt_q <= $past(limit)));

endmodule

// File: rtl/pcm_frame_ctr.sv
module pcm_frame_ctr #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         adv,
    input  logic [W-1:0] limit,
    output logic         at_start
);

    logic [W-1:0] bit_q;

    assign at_start = (bit_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_q <= '0;
        end else if (clr) begin
            bit_q <= '0;
        end else if (adv) begin
            if (bit_q == limit) bit_q <= '0;
            else                bit_q <= bit_q + 1'b1;
        end
    end

    assert_frame_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (bit_q <= $past(limit)));

    assert_frame_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && adv && (bit_q == limit)) |=> at_start);

endmodule

// File: rtl/pcm_clkgen.sv
module pcm_clkgen
    import pcm_clkgen_pkg::*;
#(
    parameter int SYNC_RST = 127,
    parameter int DIV_RST  = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             tick_audio,
    input  logic             tick_bus,
    input  logic             port_active,
    input  logic             keep_idle_clk,
    output logic             bclk,
    output logic             bclk_rise,
    output logic             bclk_fall,
    output logic             fsync
);

    clk_cfg_t   cfg;
    gen_state_e st_q, st_d;
    logic       src_tick, run, cnt_clr;
    logic       half_term, at_start;
    logic       rise_d, fall_d;

    pcm_cfg_reg #(
        .SYNC_RST (SYNC_RST),
        .DIV_RST  (DIV_RST)
    ) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (cfg_wr),
        .wdata (cfg_wdata),
        .cfg   (cfg)
    );

    assign src_tick = cfg.src_sel ? tick_bus : tick_audio;
    assign run      = cfg.ser_en && (port_active || keep_idle_clk);
    assign cnt_clr  = cfg_wr || !run || (st_q == ST_OFF);

    pcm_tick_div #(.W(DIV_W)) u_half (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .tick  (src_tick),
        .limit (cfg.bclk_div),
        .term  (half_term)
    );

    pcm_frame_ctr #(.W(DIV_W)) u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (cnt_clr),
        .adv      (fall_d),
        .limit    (cfg.sync_div),
        .at_start (at_start)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_OFF;
        else        st_q <= st_d;
    end

    // Next state and toggle events
    always_comb begin
        st_d   = st_q;
        rise_d = 1'b0;
        fall_d = 1'b0;
        if (cfg_wr || !run) begin
            st_d = ST_OFF;
        end else begin
            unique case (st_q)
                ST_OFF:  st_d = ST_LOW;
                ST_LOW:  if (half_term) begin
                             st_d   = ST_HIGH;
                             rise_d = 1'b1;
                         end
                ST_HIGH: if (half_term) begin
                             st_d   = ST_LOW;
                             fall_d = 1'b1;
                         end
                default: st_d = ST_OFF;
            endcase
        end
    end

    // Output process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bclk_rise <= 1'b0;
            bclk_fall <= 1'b0;
        end else begin
            bclk_rise <= rise_d;
            bclk_fall <= fall_d;
        end
    end

    assign bclk  = (st_q == ST_HIGH);
    assign fsync = (st_q != ST_OFF) && at_start;

    assert_rise_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bclk) |-> bclk_rise);

    assert_fall_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bclk_fall |-> (!bclk && $past(bclk)));

    assert_wr_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> (!bclk && !fsync && !bclk_rise && !bclk_fall));

    assert_gated_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg.ser_en) |=> (!bclk && !fsync));

    assert_idle_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!port_active && !keep_idle_clk) |=> (!bclk && !fsync));

endmodule

// File: tb/sim_pcm_clkgen.sv
module sim_pcm_clkgen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [19:0] cfg_wdata = '0;
    logic        tick_audio = 1'b0;
    logic        tick_bus = 1'b0;
    logic        port_active = 1'b0;
    logic        keep_idle_clk = 1'b0;
    logic        bclk, bclk_rise, bclk_fall, fsync;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit model_on = 1'b0;

    always #10 clk = ~clk;

    pcm_clkgen u0 (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .tick_audio(tick_audio), .tick_bus(tick_bus),
        .port_active(port_active), .keep_idle_clk(keep_idle_clk),
        .bclk(bclk), .bclk_rise(bclk_rise), .bclk_fall(bclk_fall), .fsync(fsync)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
        end
    endtask

    function automatic logic [19:0] pack_cfg(input bit en, input bit sel, input int n, input int s);
        return {en, sel, 9'(n), 9'(s)};
    endfunction

    // Reference model built from the requirements
    int  m_n, m_s, m_ticks, m_bit;
    bit  m_en, m_sel, m_going, m_hi, m_rise, m_fall;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_en = 0; m_sel = 0; m_n = 0; m_s = 127;
            m_going = 0; m_hi = 0; m_ticks = 0; m_bit = 0; m_rise = 0; m_fall = 0;
        end else begin
            bit go_now, tk;
            go_now = m_en && (port_active || keep_idle_clk);
            tk     = m_sel ? tick_bus : tick_audio;
            m_rise = 0; m_fall = 0;
            if (cfg_wr || !go_now) begin
                if (cfg_wr) begin
                    m_s   = int'(cfg_wdata[8:0]);
                    m_n   = int'(cfg_wdata[17:9]);
                    m_sel = cfg_wdata[18];
                    m_en  = cfg_wdata[19];
                end
                m_going = 0; m_hi = 0; m_ticks = 0; m_bit = 0;
            end else if (!m_going) begin
                m_going = 1;
            end else if (tk) begin
                if (m_ticks < m_n) begin
                    m_ticks++;
                end else begin
                    m_ticks = 0;
                    if (!m_hi) begin
                        m_hi = 1; m_rise = 1;
                    end else begin
                        m_hi = 0; m_fall = 1;
                        m_bit = (m_bit >= m_s) ? 0 : m_bit + 1;
                    end
                end
            end
        end
    end

    always @(negedge clk) begin
        if (model_on && rst_n) begin
            check(bclk == m_hi, "R3 bclk vs model", bclk, m_hi);
            check(fsync == (m_going && m_bit == 0), "R5 fsync vs model", fsync, m_going && m_bit == 0);
            check(bclk_rise == m_rise, "R6 rise pulse vs model", bclk_rise, m_rise);
            check(bclk_fall == m_fall, "R6 fall pulse vs model", bclk_fall, m_fall);
        end
    end

    task automatic write_cfg(input logic [19:0] w);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_wdata = w;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=%0d expected=0", cyc);
            finish_run();
        end
    end

    initial begin
        int c, t0, t1, seen;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R2: reset state
        check(!bclk && !bclk_rise && !bclk_fall && !fsync, "R2 reset outputs", {bclk, bclk_rise, bclk_fall, fsync}, 0);
        rst_n = 1'b1;
        model_on = 1'b1;
        repeat (5) @(negedge clk);
        check(!bclk && !fsync, "R2 enable clear after reset", {bclk, fsync}, 0);

        // R10 / R1: first rise timing with N=2, S=3, audio source
        keep_idle_clk = 1'b1; tick_audio = 1'b1; tick_bus = 1'b0;
        @(negedge clk);
        cfg_wr = 1'b1; cfg_wdata = pack_cfg(1, 0, 2, 3);
        @(negedge clk);
        cfg_wr = 1'b0; c = 1;
        while (!bclk_rise && c < 50) begin @(negedge clk); c++; end
        check(c == 5, "R10 first rise delay", c, 5);

        // R3: rise-to-rise period 2*(N+1)
        c = 0;
        do begin @(negedge clk); c++; end while (!bclk_rise && c < 50);
        check(c == 6, "R3 bit clock period N=2", c, 6);

        // R5: fsync period (S+1)*2*(N+1) and width 2*(N+1)
        while (fsync) @(negedge clk);
        while (!fsync) @(negedge clk);
        t0 = cyc; c = 0;
        while (fsync) begin @(negedge clk); c++; end
        check(c == 6, "R5 fsync width", c, 6);
        while (!fsync) @(negedge clk);
        t1 = cyc;
        check(t1 - t0 == 24, "R5 fsync period", t1 - t0, 24);

        // R1: bit 18 selects bus source; N=1 gives period 4
        tick_bus = 1'b1;
        write_cfg(pack_cfg(1, 1, 1, 0));
        while (!bclk_rise) @(negedge clk);
        c = 0;
        do begin @(negedge clk); c++; end while (!bclk_rise && c < 50);
        check(c == 4, "R1 bus source N=1 period", c, 4);

        // R4: ticks only on unselected source
        tick_bus = 1'b0; tick_audio = 1'b1;
        write_cfg(pack_cfg(1, 1, 0, 0));
        seen = 0;
        repeat (40) begin @(negedge clk); if (bclk || bclk_rise) seen++; end
        check(seen == 0, "R4 unselected ticks ignored", seen, 0);

        // R7: write while bclk is high
        tick_audio = 1'b1;
        write_cfg(pack_cfg(1, 0, 3, 2));
        while (!bclk) @(negedge clk);
        cfg_wr = 1'b1; cfg_wdata = pack_cfg(1, 0, 3, 2);
        @(negedge clk);
        cfg_wr = 1'b0;
        check(!bclk && !fsync && !bclk_rise && !bclk_fall, "R7 restart after write",
              {bclk, fsync, bclk_rise, bclk_fall}, 0);

        // R8: enable clear keeps outputs low
        tick_bus = 1'b1;
        write_cfg(pack_cfg(0, 0, 0, 0));
        seen = 0;
        repeat (30) begin @(negedge clk); if (bclk || fsync) seen++; end
        check(seen == 0, "R8 disabled outputs low", seen, 0);

        // R9: continuous vs gated idle
        write_cfg(pack_cfg(1, 0, 0, 1));
        port_active = 1'b0; keep_idle_clk = 1'b1;
        seen = 0;
        repeat (20) begin @(negedge clk); if (bclk_rise) seen++; end
        check(seen > 0, "R9 continuous idle runs", seen, 1);
        while (!bclk) @(negedge clk);
        keep_idle_clk = 1'b0;
        @(negedge clk);
        check(!bclk && !fsync, "R9 gated idle stops", {bclk, fsync}, 0);
        port_active = 1'b1;
        seen = 0;
        repeat (20) begin @(negedge clk); if (bclk_rise) seen++; end
        check(seen > 0, "R9 active port runs", seen, 1);

        // Random phase with colliding writes, stops and toggles
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            tick_audio = ($urandom % 2) == 0;
            tick_bus   = ($urandom % 3) == 0;
            if ($urandom % 150 == 0) port_active = ~port_active;
            if ($urandom % 400 == 0) keep_idle_clk = ~keep_idle_clk;
            cfg_wr = ($urandom % 120) == 0;
            cfg_wdata = pack_cfg(($urandom % 8) != 0, $urandom % 2, $urandom % 4, $urandom % 6);
        end
        @(negedge clk);
        cfg_wr = 1'b0;
        repeat (5) @(negedge clk);
        finish_run();
    end

endmodule